// File: doc/BRIEF.md
# Branch History Table Predictor

This block steers an instruction prefetch unit. Every cycle it looks up the current prefetch address in a small table of recently resolved branches. Each table slot holds a branch address tag, the last taken target, and a two-bit saturating history. If no slot matches, or the matching slot's history leans toward not taken, the block offers the next sequential address as the next prefetch address. If the history leans toward taken, it offers the stored target instead.

When a branch resolves in the execute stage, the stage reports four things: the branch address, its target, the actual direction, and the direction that was predicted for it. A known branch has its history stepped toward the actual outcome. An unknown branch claims a slot, replacing existing slots in round-robin order. If the actual direction differs from the predicted one, the block raises a redirect carrying the correct address, and that address overrides the prediction on the next-address output in the same cycle.

Top module: `bht_predictor`

## Requirements
- R1: After synchronous active-low reset every slot is empty, so no prefetch address hits and `next_pc` equals `fetch_pc + 1`.
- R2: When `fetch_pc` matches no valid slot and no redirect is active, `pred_hit` and `pred_taken` are 0 and `next_pc` is `fetch_pc + 1`.
- R3: When `fetch_pc` matches a slot, `pred_taken` is the top bit of that slot's history. `next_pc` is the stored target when that bit is 1 and `fetch_pc + 1` when it is 0.
- R4: The history encoding is 11 strongly taken, 10 weakly taken, 01 weakly not taken and 00 strongly not taken. A resolution moves a matching slot one step toward its outcome and saturates at 11 and 00. A taken resolution also rewrites the stored target.
- R5: A resolved branch that matches no slot is written into a slot with its tag and target. Its history starts at 10 if the branch was taken and at 01 if it was not.
- R6: New slots are taken in round-robin order over all 8 slots. After 8 allocations, the ninth replaces the slot allocated first.
- R7: `redirect_valid` is high in the cycle where a resolution's actual direction differs from its reported predicted direction. `redirect_pc` is then the resolved target if the branch was taken and the branch address plus 1 if it was not.
- R8: While `redirect_valid` is high, `next_pc` equals `redirect_pc`, whatever the lookup yields.
- R9: A lookup and a resolution that hit the same slot in the same cycle: the lookup sees the slot's history from before the update.
- R10: A slot in a strong state flips its predicted direction only after two consecutive opposite outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | ADDR_W | Current prefetch address being looked up |
| next_pc | output | ADDR_W | Chosen next prefetch address |
| pred_hit | output | 1 | `fetch_pc` matched a valid slot |
| pred_taken | output | 1 | Lookup predicts taken |
| resolve_valid | input | 1 | A conditional branch resolves this cycle |
| resolve_pc | input | ADDR_W | Address of the resolving branch |
| resolve_target | input | ADDR_W | Taken target of the resolving branch |
| resolve_taken | input | 1 | Actual direction |
| resolve_pred_taken | input | 1 | Direction that was predicted for this branch |
| redirect_valid | output | 1 | Misprediction, fetch must restart |
| redirect_pc | output | ADDR_W | Correct restart address |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a lookup and a history update on the same slot. The bench drives `fetch_pc` equal to `resolve_pc` while that branch resolves against its history. It expects the prediction from the old state in that cycle and the stepped state on the next lookup. The second pair is a misprediction redirect and a lookup that hits a taken slot. The bench provokes this and judges `next_pc` against the redirect address, not the stored target. A long pseudo-random run over twelve branch addresses exercises both collisions many times, together with evictions. A bench-side table model judges every cycle.

// File: rtl/bht_pkg.sv
// Shared types for the branch history table predictor.
// Assumes a two-bit history whose top bit is the predicted direction.
package bht_pkg;
    typedef enum logic [1:0] {
        HIST_STRONG_NT = 2'b00,
        HIST_WEAK_NT   = 2'b01,
        HIST_WEAK_T    = 2'b10,
        HIST_STRONG_T  = 2'b11
    } hist_t;
endpackage

// File: rtl/bht_hist_step.sv
// Next-state logic of one two-bit saturating history.
// Assumes the caller only applies the result when a resolution hits the slot.
module bht_hist_step
    import bht_pkg::*;
(
    input  hist_t cur,
    input  logic  taken,
    output hist_t nxt
);
    // Step one state toward the outcome, saturating at both ends.
    always_comb begin
        unique case (cur)
            HIST_STRONG_NT: nxt = taken ? HIST_WEAK_NT  : HIST_STRONG_NT;
            HIST_WEAK_NT:   nxt = taken ? HIST_WEAK_T   : HIST_STRONG_NT;
            HIST_WEAK_T:    nxt = taken ? HIST_STRONG_T : HIST_WEAK_NT;
            default:        nxt = taken ? HIST_STRONG_T : HIST_WEAK_T;
        endcase
    end
endmodule

// File: rtl/bht_match.sv
// Fully associative tag compare over all slots.
// Assumes tags are unique among valid slots; the lowest index wins otherwise.
module bht_match #(
    parameter  int ADDR_W  = 16,
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign eq[e] = ent_valid[e] && (ent_tag[e] == addr);
    end

    // Reduce the match vector to a flag and a slot number.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (eq[e]) idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/bht_table.sv
// Slot storage: valid, tag, target, history, plus the round-robin pointer.
// Assumes upd_hit/upd_idx come from a compare against the current contents.
module bht_table
    import bht_pkg::*;
#(
    parameter  int ADDR_W  = 16,
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           upd_en,
    input  logic                           upd_hit,
    input  logic [IDX_W-1:0]               upd_idx,
    input  logic [ADDR_W-1:0]              upd_pc,
    input  logic [ADDR_W-1:0]              upd_tgt,
    input  logic                           upd_taken,
    output logic [ENTRIES-1:0]             ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent_tgt,
    output logic [ENTRIES-1:0][1:0]        ent_hist,
    output logic [IDX_W-1:0]               alloc_ptr
);
    logic do_alloc;
    assign do_alloc = upd_en && !upd_hit;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        hist_t step_nxt;
        logic  wr_hit;
        logic  wr_new;

        bht_hist_step u_step (
            .cur   (hist_t'(ent_hist[e])),
            .taken (upd_taken),
            .nxt   (step_nxt)
        );

        assign wr_hit = upd_en && upd_hit && (upd_idx == IDX_W'(e));
        assign wr_new = do_alloc && (alloc_ptr == IDX_W'(e));

        // Fill a slot on allocation or step its history on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[e] <= 1'b0;
                ent_tag[e]   <= '0;
                ent_tgt[e]   <= '0;
                ent_hist[e]  <= HIST_STRONG_NT;
            end else if (wr_new) begin
                ent_valid[e] <= 1'b1;
                ent_tag[e]   <= upd_pc;
                ent_tgt[e]   <= upd_tgt;
                ent_hist[e]  <= upd_taken ? HIST_WEAK_T : HIST_WEAK_NT;
            end else if (wr_hit) begin
                ent_hist[e] <= step_nxt;
                if (upd_taken) ent_tgt[e] <= upd_tgt;
            end
        end
    end

    // Advance the replacement pointer after each allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr <= '0;
        end else if (do_alloc) begin
            alloc_ptr <= (alloc_ptr == IDX_W'(ENTRIES - 1)) ? '0 : alloc_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/bht_predictor.sv
// Branch history table predictor: lookup, next-address select, resolution
// update with round-robin allocation, and misprediction redirect.
// Assumes at most one resolution per cycle; redirect outranks prediction.
module bht_predictor #(
    parameter  int ADDR_W  = 16,
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    input  logic              resolve_valid,
    input  logic [ADDR_W-1:0] resolve_pc,
    input  logic [ADDR_W-1:0] resolve_target,
    input  logic              resolve_taken,
    input  logic              resolve_pred_taken,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_tgt;
    logic [ENTRIES-1:0][1:0]        ent_hist;
    logic [IDX_W-1:0]               alloc_ptr;
    logic [IDX_W-1:0]               lk_idx;
    logic                           upd_hit;
    logic [IDX_W-1:0]               upd_idx;

    bht_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_fetch_match (
        .addr      (fetch_pc),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .hit       (pred_hit),
        .idx       (lk_idx)
    );

    bht_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_resolve_match (
        .addr      (resolve_pc),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .hit       (upd_hit),
        .idx       (upd_idx)
    );

    bht_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (resolve_valid),
        .upd_hit   (upd_hit),
        .upd_idx   (upd_idx),
        .upd_pc    (resolve_pc),
        .upd_tgt   (resolve_target),
        .upd_taken (resolve_taken),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .ent_tgt   (ent_tgt),
        .ent_hist  (ent_hist),
        .alloc_ptr (alloc_ptr)
    );

    // Detect a wrong direction and form the restart address.
    always_comb begin
        redirect_valid = resolve_valid && (resolve_taken != resolve_pred_taken);
        redirect_pc    = resolve_taken ? resolve_target : resolve_pc + ADDR_W'(1);
    end

    // Choose the next prefetch address: redirect, predicted target or sequential.
    always_comb begin
        pred_taken = pred_hit && ent_hist[lk_idx][1];
        if (redirect_valid)  next_pc = redirect_pc;
        else if (pred_taken) next_pc = ent_tgt[lk_idx];
        else                 next_pc = fetch_pc + ADDR_W'(1);
    end
endmodule

// File: rtl/bht_checker.sv
// Protocol and behaviour properties for bht_predictor, bound to every instance.
// Assumes the internal resolve-hit flag and the allocation pointer are visible.
module bht_checker #(
    parameter  int ADDR_W  = 16,
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic              pred_hit,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              resolve_valid,
    input logic [ADDR_W-1:0] resolve_pc,
    input logic [ADDR_W-1:0] resolve_target,
    input logic              resolve_taken,
    input logic              resolve_pred_taken,
    input logic              upd_hit,
    input logic [IDX_W-1:0]  alloc_ptr
);
    // R1: one cycle of reset empties every slot.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> !pred_hit);

    // R2: a miss without redirect fetches sequentially.
    assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_hit && !redirect_valid) |-> (next_pc == fetch_pc + ADDR_W'(1)));

    // R7: redirect only on a direction mismatch, to the correct address.
    assert_redirect_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (resolve_valid && (resolve_taken != resolve_pred_taken) &&
                            (redirect_pc == (resolve_taken ? resolve_target
                                                           : resolve_pc + ADDR_W'(1)))));

    // R8: redirect outranks the lookup on the next-address output.
    assert_redirect_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (next_pc == redirect_pc));

    // R6: each allocation advances the round-robin pointer by one, wrapping.
    assert_rr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !upd_hit) |=>
            (alloc_ptr == (($past(alloc_ptr) == IDX_W'(ENTRIES - 1)) ? '0
                                                                     : $past(alloc_ptr) + 1'b1)));

    // R6: without an allocation the pointer holds.
    assert_rr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(resolve_valid && !upd_hit) |=> $stable(alloc_ptr));
endmodule

bind bht_predictor bht_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_bht_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .fetch_pc           (fetch_pc),
    .next_pc            (next_pc),
    .pred_hit           (pred_hit),
    .redirect_valid     (redirect_valid),
    .redirect_pc        (redirect_pc),
    .resolve_valid      (resolve_valid),
    .resolve_pc         (resolve_pc),
    .resolve_target     (resolve_target),
    .resolve_taken      (resolve_taken),
    .resolve_pred_taken (resolve_pred_taken),
    .upd_hit            (upd_hit),
    .alloc_ptr          (alloc_ptr)
);

// File: tb/bht_predictor_test.sv
// Self-checking bench: a table model judges every cycle of directed and random runs.
module bht_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] next_pc;
    logic          pred_hit, pred_taken;
    logic          resolve_valid = 1'b0;
    logic [AW-1:0] resolve_pc = '0;
    logic [AW-1:0] resolve_target = '0;
    logic          resolve_taken = 1'b0;
    logic          resolve_pred_taken = 1'b0;
    logic          redirect_valid;
    logic [AW-1:0] redirect_pc;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench-side table model.
    bit            m_valid [NE];
    logic [AW-1:0] m_tag   [NE];
    logic [AW-1:0] m_tgt   [NE];
    int            m_st    [NE];
    int            m_ptr;

    bht_predictor #(.ADDR_W(AW), .ENTRIES(NE)) uut (
        .clk                (clk),
        .rst_n              (rst_n),
        .fetch_pc           (fetch_pc),
        .next_pc            (next_pc),
        .pred_hit           (pred_hit),
        .pred_taken         (pred_taken),
        .resolve_valid      (resolve_valid),
        .resolve_pc         (resolve_pc),
        .resolve_target     (resolve_target),
        .resolve_taken      (resolve_taken),
        .resolve_pred_taken (resolve_pred_taken),
        .redirect_valid     (redirect_valid),
        .redirect_pc        (redirect_pc)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, judge the outputs against the model, then advance the model.
    task automatic cyc(input string tag, input logic [AW-1:0] fpc, input bit rv,
                       input logic [AW-1:0] rpc, input logic [AW-1:0] rtg,
                       input bit rt, input bit rp);
        int h;
        int e_hit, e_tk, e_rv;
        logic [AW-1:0] e_rpc, e_next;
        @(negedge clk);
        fetch_pc = fpc; resolve_valid = rv; resolve_pc = rpc;
        resolve_target = rtg; resolve_taken = rt; resolve_pred_taken = rp;
        #1;
        h = m_find(fpc);
        e_hit = (h >= 0);
        e_tk  = (h >= 0) ? (m_st[h] >= 2) : 0;
        e_rv  = rv && (rt != rp);
        e_rpc = rt ? rtg : rpc + 16'd1;
        e_next = e_rv ? e_rpc : (e_tk ? m_tgt[h] : fpc + 16'd1);
        chk(tag, "pred_hit", int'(pred_hit), e_hit);
        chk(tag, "pred_taken", int'(pred_taken), e_tk);
        chk(tag, "redirect_valid", int'(redirect_valid), e_rv);
        if (e_rv) chk(tag, "redirect_pc", int'(redirect_pc), int'(e_rpc));
        chk(tag, "next_pc", int'(next_pc), int'(e_next));
        @(posedge clk);
        if (rv) begin
            h = m_find(rpc);
            if (h >= 0) begin
                m_st[h] = rt ? ((m_st[h] == 3) ? 3 : m_st[h] + 1)
                             : ((m_st[h] == 0) ? 0 : m_st[h] - 1);
                if (rt) m_tgt[h] = rtg;
            end else begin
                m_valid[m_ptr] = 1'b1; m_tag[m_ptr] = rpc; m_tgt[m_ptr] = rtg;
                m_st[m_ptr] = rt ? 2 : 1;
                m_ptr = (m_ptr + 1) % NE;
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_st[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty after reset.
        cyc("R1", 16'h0040, 0, 0, 0, 0, 0);
        cyc("R2", 16'h0010, 0, 0, 0, 0, 0);
        // R5 and R7: allocate a taken branch, mispredicted as not taken.
        cyc("R7", 16'h0000, 1, 16'h0010, 16'h0080, 1, 0);
        cyc("R5", 16'h0010, 0, 0, 0, 0, 0);
        cyc("R5", 16'h0020, 1, 16'h0020, 16'h0090, 0, 0);
        cyc("R5", 16'h0020, 0, 0, 0, 0, 0);
        // R4: saturate at strongly taken.
        cyc("R4", 16'h0000, 1, 16'h0010, 16'h0080, 1, 1);
        cyc("R4", 16'h0000, 1, 16'h0010, 16'h0084, 1, 1);
        cyc("R4", 16'h0010, 0, 0, 0, 0, 0);
        // R10: two consecutive not-taken outcomes needed to flip.
        cyc("R7", 16'h0000, 1, 16'h0010, 16'h0084, 0, 1);
        cyc("R10", 16'h0010, 0, 0, 0, 0, 0);
        cyc("R7", 16'h0000, 1, 16'h0010, 16'h0084, 0, 1);
        cyc("R10", 16'h0010, 0, 0, 0, 0, 0);
        // R9: same-cycle lookup and update of one slot see the old state.
        cyc("R9", 16'h0020, 1, 16'h0020, 16'h0090, 1, 1);
        cyc("R9", 16'h0020, 1, 16'h0020, 16'h0090, 1, 0);
        cyc("R9", 16'h0020, 0, 0, 0, 0, 0);
        // R8: redirect overrides a taken hit.
        cyc("R8", 16'h0020, 1, 16'h0010, 16'h0084, 0, 1);
        // R6: fill all slots, then evict the oldest.
        for (int k = 3; k <= 9; k++)
            cyc("R6", 16'h0000, 1, AW'(k * 16), AW'(k * 16 + 8), k[0], k[0]);
        cyc("R6", 16'h0010, 0, 0, 0, 0, 0);
        cyc("R6", 16'h0020, 0, 0, 0, 0, 0);
        cyc("R6", 16'h0090, 0, 0, 0, 0, 0);

        // Pseudo-random sweep over twelve branch addresses.
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] fp, rp;
            string tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fp = 16'h0100 + AW'((lfsr[3:0] % 12) * 4);
            rp = 16'h0100 + AW'((lfsr[11:8] % 12) * 4);
            if (lfsr[4] && (lfsr[5] != lfsr[6])) tg = "R8";
            else if (m_find(fp) >= 0) tg = "R3";
            else tg = "R2";
            cyc(tg, fp, lfsr[4], rp, rp ^ 16'h0F00 ^ {12'h0, lfsr[15:12]},
                lfsr[5], lfsr[6]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule